// File: doc/BRIEF.md
# Multiplexed Address/Data Byte Memory Port

This block is a clock-synchronous model of a byte-wide static memory. The memory is reached over one shared 8-bit bus that carries both address and data. The address is assembled from two pieces. Each piece is captured from the bus by its own address strobe, and the pieces may arrive in either order. A captured piece stays in place until its own strobe fires again. A host can therefore repeat accesses to a neighbouring location by re-strobing only the half that changes.

Read and write strobes move bytes between the bus and the internal array. Both take effect only while the chip enable is active. A power-fail input deselects the whole device: the bus is released, every input is ignored and no location can change. A read overlapping a write is a protocol fault. It is reported on an error output and has no other effect. The default array holds 4096 bytes (12 address bits). The width of the high address half follows from the address-width parameter.

All control strobes except the address strobes are active-low. The address strobes act on their rising edge. Every edge is found by comparing an input with its value on the previous clock.

Top module: `muxSramPort`

## Requirements
- R1: A rising edge on `asLo` loads `busIn[7:0]` into address bits 7:0 on that clock edge.
- R2: A rising edge on `asHi` loads `busIn[3:0]` into address bits 11:8. Bus bits 7:4 have no effect on the address.
- R3: The two halves may be loaded in either order, and each strobe changes only its own half.
- R4: A loaded half is kept across any number of later reads and writes until its own strobe fires again.
- R5: Read and write act only while `ceN` is low. The address strobes load the address whatever the level of `ceN`.
- R6: A write stores `busIn` at the current address on the clock where an enabled `wrN` first goes low. Holding `wrN` low stores no further byte.
- R7: With `ceN` and `rdN` low, `busOe` is high from the next clock with `busOut` equal to the addressed byte. `busOe` drops in the same cycle that `rdN` or `ceN` goes high.
- R8: When `ceN`, `rdN` and `wrN` are all low, `protoErr` is high, nothing is written and `busOe` is low.
- R9: While `pwrFail` is high, `busOe` is low, no write occurs and the address strobes are ignored.
- R10: After reset both address halves are zero and `busOe` is low. Array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busIn | input | 8 | Bus value seen by the device |
| busOut | output | 8 | Byte driven onto the bus (zero when not enabled) |
| busOe | output | 1 | Bus output enable |
| asLo | input | 1 | Low address strobe, acts on rising edge |
| asHi | input | 1 | High address strobe, acts on rising edge |
| rdN | input | 1 | Read strobe, active-low |
| wrN | input | 1 | Write strobe, active-low |
| ceN | input | 1 | Chip enable, active-low |
| pwrFail | input | 1 | Power-fail deselect, active-high |
| protoErr | output | 1 | High while read and write are enabled together |

## Verification
An address strobe that rises before a clock edge loads its half at that edge. A write lands at the first edge after `wrN` falls. The bench drives every input at the falling clock edge, so each of these effects is already in place by the next falling edge. Read data and `busOe` are due one full clock after the read strobe is first sampled, and the bench checks them at the falling edge that follows. It then releases `rdN` and, one time unit later, checks that `busOe` is already low in that same cycle. `protoErr` is combinational and is checked after one clock with the fault condition held. Every write, deselected write and power-fail attempt is judged later by a read at the port against a model array kept in the bench.

// File: rtl/muxsram_pkg.sv
package muxsram_pkg;
  typedef struct packed {
    logic latchLo;
    logic latchHi;
    logic doWrite;
    logic doRead;
  } strobe_t;
endpackage

// File: rtl/muxSramCtrl.sv
module muxSramCtrl
  import muxsram_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    asLo,
  input  logic    asHi,
  input  logic    rdN,
  input  logic    wrN,
  input  logic    ceN,
  input  logic    pwrFail,
  output strobe_t stb,
  output logic    busOe,
  output logic    protoErr
);
  logic asLoQ, asHiQ, wrRawQ, rdActQ;
  logic wrRaw, rdRaw, conflict, rdAct;

  assign wrRaw    = !ceN && !wrN;
  assign rdRaw    = !ceN && !rdN;
  assign conflict = wrRaw && rdRaw && !pwrFail;
  assign rdAct    = rdRaw && wrN && !pwrFail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asLoQ  <= 1'b1;
      asHiQ  <= 1'b1;
      wrRawQ <= 1'b0;
      rdActQ <= 1'b0;
    end else begin
      asLoQ  <= asLo;
      asHiQ  <= asHi;
      wrRawQ <= wrRaw;
      rdActQ <= rdAct;
    end
  end

  always_comb begin
    stb.latchLo = asLo && !asLoQ && !pwrFail;
    stb.latchHi = asHi && !asHiQ && !pwrFail;
    stb.doWrite = wrRaw && !wrRawQ && rdN && !pwrFail;
    stb.doRead  = rdAct;
  end

  assign busOe    = rdAct && rdActQ;
  assign protoErr = conflict;

  // R8: a conflicting access never produces a write strobe
  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> !stb.doWrite);
  // R6: one falling write strobe gives exactly one write
  p_one_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |=> !stb.doWrite);
endmodule

// File: rtl/muxSramData.sv
module muxSramData
  import muxsram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] addrLo;
  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] mem [DEPTH];

  assign addr = {addrHi, addrLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
    end else begin
      if (stb.latchLo) addrLo <= busIn;
      if (stb.latchHi) addrHi <= busIn[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && stb.doWrite) mem[addr] <= busIn;
  end

  always_ff @(posedge clk) begin
    if (stb.doRead) rdData <= mem[addr];
  end

  // R1: low strobe loads bus into low half
  p_lo_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchLo |=> addrLo == $past(busIn));
  // R2: high strobe loads only the low bus bits into high half
  p_hi_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchHi |=> addrHi == $past(busIn[HI_W-1:0]));
  // R3/R4: a half is untouched unless its own strobe fires
  p_lo_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchLo |=> $stable(addrLo));
  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchHi |=> $stable(addrHi));
  // R6: the written byte lands at the address that was current
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |=> mem[$past(addr)] == $past(busIn));
endmodule

// File: rtl/muxSramPort.sv
module muxSramPort
  import muxsram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              asLo,
  input  logic              asHi,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              ceN,
  input  logic              pwrFail,
  output logic              protoErr
);
  strobe_t           stb;
  logic [DATA_W-1:0] rdData;
  logic              oeInt;

  muxSramCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .asLo(asLo), .asHi(asHi), .rdN(rdN),
    .wrN(wrN), .ceN(ceN), .pwrFail(pwrFail), .stb(stb),
    .busOe(oeInt), .protoErr(protoErr)
  );

  muxSramData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .busIn(busIn), .rdData(rdData)
  );

  assign busOe  = oeInt;
  assign busOut = oeInt ? rdData : '0;

  // R9: power fail releases the bus
  p_pf_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> !busOe);
  // R5/R7: no drive without chip enable and read strobe
  p_ce_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || rdN) |-> !busOe);
  // R8: conflicting strobes never drive the bus
  p_conflict_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !rdN && !wrN) |-> !busOe);
endmodule

// File: tb/tb_muxSramPort.sv
module tb_muxSramPort;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic       busOe, protoErr;
  logic       asLo = 1'b1, asHi = 1'b1, rdN = 1'b1, wrN = 1'b1, ceN = 1'b1, pwrFail = 1'b0;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;
  logic [7:0] model [4096];
  bit         valid [4096];
  logic [7:0] mLo = '0;
  logic [3:0] mHi = '0;

  always #2 clk = ~clk;

  muxSramPort dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .asLo(asLo), .asHi(asHi), .rdN(rdN), .wrN(wrN), .ceN(ceN),
    .pwrFail(pwrFail), .protoErr(protoErr)
  );

  function automatic logic [11:0] curAddr();
    return {mHi, mLo};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobeLo(logic [7:0] v, logic ce);
    @(negedge clk); busIn = v; ceN = ce; asLo = 1'b0;
    @(negedge clk); asLo = 1'b1;
    @(negedge clk); ceN = 1'b1;
    if (!pwrFail) mLo = v;
  endtask

  task automatic strobeHi(logic [7:0] v, logic ce);
    @(negedge clk); busIn = v; ceN = ce; asHi = 1'b0;
    @(negedge clk); asHi = 1'b1;
    @(negedge clk); ceN = 1'b1;
    if (!pwrFail) mHi = v[3:0];
  endtask

  task automatic writeByte(logic [7:0] v);
    @(negedge clk); busIn = v; ceN = 1'b0; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1; ceN = 1'b1;
    if (!pwrFail) begin model[curAddr()] = v; valid[curAddr()] = 1; end
  endtask

  task automatic readCheck(string req);
    logic [7:0] exp;
    exp = model[curAddr()];
    @(negedge clk); ceN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    check(busOe === 1'b1, req, busOe, 1);
    check(busOut === exp, req, busOut, exp);
    rdN = 1'b1; ceN = 1'b1;
    #1 check(busOe === 1'b0, "R7 drop", busOe, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busOe === 1'b0, "R10 oe", busOe, 0);
    check(protoErr === 1'b0, "R10 err", protoErr, 0);
    // R10: address is zero after reset: write without strobes, then reach 0 explicitly
    writeByte(8'hA5);
    strobeLo(8'h05, 1'b1); writeByte(8'h11);
    strobeLo(8'h00, 1'b1);
    readCheck("R10 addr zero");
    // R2: upper bus bits ignored on high strobe
    strobeHi(8'hF3, 1'b0); strobeLo(8'h40, 1'b0); writeByte(8'h77);
    strobeHi(8'h03, 1'b1);
    readCheck("R2 high bits ignored");
    // R3: reverse order, only own half changes
    strobeLo(8'h41, 1'b1); writeByte(8'h88);
    strobeLo(8'h40, 1'b1);
    readCheck("R3 lo only");
    // R4: repeated access without strobes
    readCheck("R4 persist"); readCheck("R4 persist again");
    // R6: held write stores one byte
    @(negedge clk); busIn = 8'h5A; ceN = 1'b0; wrN = 1'b0;
    @(negedge clk); busIn = 8'hC3;
    @(negedge clk); wrN = 1'b1; ceN = 1'b1;
    model[curAddr()] = 8'h5A;
    readCheck("R6 single write");
    // R5: write and read without chip enable
    @(negedge clk); busIn = 8'h99; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); rdN = 1'b0;
    @(negedge clk);
    check(busOe === 1'b0, "R5 read needs ce", busOe, 0);
    rdN = 1'b1;
    readCheck("R5 write needs ce");
    // R8: conflict
    @(negedge clk); busIn = 8'h3C; ceN = 1'b0; rdN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    check(protoErr === 1'b1, "R8 err flag", protoErr, 1);
    check(busOe === 1'b0, "R8 no drive", busOe, 0);
    rdN = 1'b1; wrN = 1'b1; ceN = 1'b1;
    readCheck("R8 no write");
    // R9: power fail
    @(negedge clk); pwrFail = 1'b1;
    strobeLo(8'hEE, 1'b0);
    writeByte(8'h12);
    @(negedge clk); ceN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    check(busOe === 1'b0, "R9 no drive", busOe, 0);
    rdN = 1'b1; ceN = 1'b1; pwrFail = 1'b0;
    readCheck("R9 no write or latch");
    // R10: contents kept across reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mLo = '0; mHi = '0;
    readCheck("R10 contents kept");
    // Random mix covering R1 through R7
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: strobeLo(8'($urandom), 1'($urandom));
        1: strobeHi(8'($urandom), 1'($urandom));
        2: writeByte(8'($urandom));
        default: if (valid[curAddr()]) readCheck("R1 random read");
                 else writeByte(8'($urandom));
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule